// File: doc/BRIEF.md
# Four-Level Nested Interrupt Controller

This block gathers interrupt requests from twelve sources, masks them with per-source enables and a global enable, and gives each source one of four priority levels. At every instruction boundary it elects one winning request and presents its vector index to the CPU. A request wins only if its level is strictly above every level currently in service. When several requests share the top eligible level, the one with the lowest source index wins.

Two of the sources are active-low external pins, decoded inside the block. Each pin can sense either a falling edge, which latches a flag, or a low level. The block keeps one in-service bit per priority level. The CPU's acknowledge strobe sets the bit for the level of the vector being taken. The return strobe clears the highest set bit, which unwinds the nesting one level at a time. While the CPU is asleep, an enabled external request drives a wake output.

Source indices are: 0 and 1 the external pins, 2 and 3 the timers, 4 serial transmit, 5 serial receive, 6 combined serial, 7 brownout, 8 watchdog/real-time clock, 9 I2C, 10 keypad, 11 comparators. `periph_req[k]` carries source k+2.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, `irq_req` and `wake` are low, no level is in service, all enables and priorities are zero, and both pins are in level mode.
- R2: A write with `cfg_sel`=0 sets the global enable from bit 7 and the enables of sources 0..6 from bits 6..0. `cfg_sel`=1 sets the enables of sources 7..11 from bits 4..0. A source is eligible only while both its own enable and the global enable are 1.
- R3: A source's level is {high bit, low bit}. The low bits of sources 0..7 are written with `cfg_sel`=2 (bit i = source i), and those of sources 8..11 with `cfg_sel`=3 bits 3..0. The high bits use `cfg_sel`=4 and `cfg_sel`=5 with the same layout.
- R4: Among eligible requests of different levels, the highest level wins, regardless of source index.
- R5: Among eligible requests of the same top level, the lowest source index wins.
- R6: A request is accepted only if its level is strictly above the highest in-service level. An acknowledge of a presented vector marks that vector's level as in service.
- R7: While level 3 is in service, no request is presented.
- R8: A return strobe clears only the highest in-service level, which lets the waiting requests of the lower levels compete again.
- R9: With bit n of the `cfg_sel`=6 register set to 1, pin n is in edge mode. Its flag is set when the pin is sampled high on one clock and low on the next. The flag is cleared when vector n is acknowledged, and the request does not return until a new falling edge.
- R10: With that bit set to 0, pin n requests exactly while it is low, and nothing is latched.
- R11: `wake` is high exactly while `sleep` is high, the global enable is on, and an external source is enabled with its request active.
- R12: `irq_req`/`irq_vec` are registered. They take the election result on the clock edge where `insn_start` is high, hold it until the next boundary, and drop on the edge where `irq_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| ext_pin_n | input | 2 | External interrupt pins, active low |
| periph_req | input | 10 | Level requests of sources 2..11 |
| insn_start | input | 1 | Instruction-boundary strobe |
| sleep | input | 1 | CPU is idle or powered down |
| irq_ack | input | 1 | CPU takes the presented vector |
| irq_ret | input | 1 | CPU returns from a handler |
| irq_req | output | 1 | A vector is presented |
| irq_vec | output | 4 | Presented source index |
| wake | output | 1 | Wake request to the clock control |

## Verification
The vector is due one register later than its stimulus. An election made with `insn_start` high is visible on the falling edge after the next rising edge. The bench's monitor compares the scoreboard entry at exactly that falling edge, and only for cycles it saw `insn_start` high. The in-service state has no port, so the checks read it through the next election after an acknowledge or return. `wake` follows a level-mode pin within the same cycle but follows an edge-mode pin one rising edge after the low sample, and the bench checks both sides of that edge.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  localparam int IRQ_NUM_SRC = 12;
  localparam int IRQ_NUM_EXT = 2;
  localparam int IRQ_NUM_LVL = 4;
  localparam int IRQ_CFG_DW  = 8;
  localparam int IRQ_VW      = $clog2(IRQ_NUM_SRC);
  localparam int IRQ_LW      = $clog2(IRQ_NUM_LVL);

  typedef logic [IRQ_VW-1:0] irq_vec_t;
  typedef logic [IRQ_LW-1:0] irq_lvl_t;

  typedef enum logic [2:0] {
    CFG_EN_A   = 3'd0,
    CFG_EN_B   = 3'd1,
    CFG_PLO_A  = 3'd2,
    CFG_PLO_B  = 3'd3,
    CFG_PHI_A  = 3'd4,
    CFG_PHI_B  = 3'd5,
    CFG_TRIG   = 3'd6
  } cfg_sel_e;
endpackage

// File: rtl/irq_ext_input.sv
module irq_ext_input (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n_i,
  input  logic edge_mode_i,
  input  logic clr_i,
  output logic req_o
);
  logic prev_q, prev_d;
  logic flag_q, flag_d;
  logic fall;

  always_comb begin
    fall   = prev_q & ~pin_n_i;
    prev_d = pin_n_i;
    flag_d = flag_q;
    if (clr_i)
      flag_d = 1'b0;
    if (edge_mode_i && fall)
      flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      flag_q <= flag_d;
    end
  end

  assign req_o = edge_mode_i ? flag_q : ~pin_n_i;

  // R9
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(edge_mode_i) && $past(prev_q) && !$past(pin_n_i));

  // R9
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i && !(edge_mode_i && prev_q && !pin_n_i) |=> !flag_q);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter import irq_nest_pkg::*; #(
  parameter int NUM_SRC = IRQ_NUM_SRC,
  parameter int NUM_LVL = IRQ_NUM_LVL,
  localparam int VW = $clog2(NUM_SRC),
  localparam int LW = $clog2(NUM_LVL)
) (
  input  logic [NUM_SRC-1:0]         req_i,
  input  logic [NUM_SRC-1:0][LW-1:0] lvl_i,
  input  logic [NUM_LVL-1:0]         allow_i,
  output logic                       win_valid_o,
  output logic [VW-1:0]              win_vec_o,
  output logic [LW-1:0]              win_lvl_o
);
  // Later assignments override earlier ones: levels ascend in the outer
  // loop, indices descend in the inner loop, so the last hit is the
  // highest level and, within it, the lowest index.
  always_comb begin
    win_valid_o = 1'b0;
    win_vec_o   = '0;
    win_lvl_o   = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
        if (req_i[i] && allow_i[l] && (lvl_i[i] == LW'(l))) begin
          win_valid_o = 1'b1;
          win_vec_o   = VW'(i);
          win_lvl_o   = LW'(l);
        end
      end
    end
  end
endmodule

// File: rtl/irq_nest_track.sv
module irq_nest_track import irq_nest_pkg::*; #(
  parameter int NUM_LVL = IRQ_NUM_LVL,
  localparam int LW = $clog2(NUM_LVL)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ack_i,
  input  logic [LW-1:0]      ack_lvl_i,
  input  logic               ret_i,
  output logic [NUM_LVL-1:0] active_o,
  output logic [NUM_LVL-1:0] allow_o
);
  logic [NUM_LVL-1:0] act_q, act_d, top_bit;

  always_comb begin
    top_bit = '0;
    for (int l = 0; l < NUM_LVL; l++)
      if (act_q[l])
        top_bit = NUM_LVL'(1) << l;
    act_d = act_q;
    if (ret_i)
      act_d = act_d & ~top_bit;
    if (ack_i)
      act_d[ack_lvl_i] = 1'b1;
    for (int l = 0; l < NUM_LVL; l++)
      allow_o[l] = ((act_q >> l) == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      act_q <= '0;
    else if (ack_i || ret_i)
      act_q <= act_d;
  end

  assign active_o = act_q;

  // R6
  ack_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i && !ret_i |=> act_q[$past(ack_lvl_i)]);

  // R8
  ret_pops_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_i && !ack_i && (act_q != '0) |=>
      ($countones(act_q) + 1 == $countones($past(act_q))));
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl import irq_nest_pkg::*; #(
  parameter int NUM_SRC = IRQ_NUM_SRC,
  parameter int NUM_EXT = IRQ_NUM_EXT,
  parameter int NUM_LVL = IRQ_NUM_LVL,
  parameter int DW      = IRQ_CFG_DW,
  localparam int VW     = $clog2(NUM_SRC),
  localparam int LW     = $clog2(NUM_LVL),
  localparam int NUM_PER = NUM_SRC - NUM_EXT,
  localparam int EN_A_N  = DW - 1,
  localparam int EN_B_N  = NUM_SRC - EN_A_N,
  localparam int PR_B_N  = NUM_SRC - DW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_sel,
  input  logic [DW-1:0]      cfg_wdata,
  input  logic [NUM_EXT-1:0] ext_pin_n,
  input  logic [NUM_PER-1:0] periph_req,
  input  logic               insn_start,
  input  logic               sleep,
  input  logic               irq_ack,
  input  logic               irq_ret,
  output logic               irq_req,
  output logic [VW-1:0]      irq_vec,
  output logic               wake
);
  logic [NUM_SRC-1:0] en_q, en_d, plo_q, plo_d, phi_q, phi_d;
  logic               gen_q, gen_d;
  logic [NUM_EXT-1:0] trig_q, trig_d;

  always_comb begin
    en_d   = en_q;
    gen_d  = gen_q;
    plo_d  = plo_q;
    phi_d  = phi_q;
    trig_d = trig_q;
    case (cfg_sel_e'(cfg_sel))
      CFG_EN_A: begin
        gen_d              = cfg_wdata[DW-1];
        en_d[EN_A_N-1:0]   = cfg_wdata[EN_A_N-1:0];
      end
      CFG_EN_B:  en_d[NUM_SRC-1:EN_A_N] = cfg_wdata[EN_B_N-1:0];
      CFG_PLO_A: plo_d[DW-1:0]          = cfg_wdata;
      CFG_PLO_B: plo_d[NUM_SRC-1:DW]    = cfg_wdata[PR_B_N-1:0];
      CFG_PHI_A: phi_d[DW-1:0]          = cfg_wdata;
      CFG_PHI_B: phi_d[NUM_SRC-1:DW]    = cfg_wdata[PR_B_N-1:0];
      CFG_TRIG:  trig_d                 = cfg_wdata[NUM_EXT-1:0];
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      gen_q  <= 1'b0;
      plo_q  <= '0;
      phi_q  <= '0;
      trig_q <= '0;
    end else if (cfg_we) begin
      en_q   <= en_d;
      gen_q  <= gen_d;
      plo_q  <= plo_d;
      phi_q  <= phi_d;
      trig_q <= trig_d;
    end
  end

  // Pending vector register
  logic          pend_vld_q, pend_vld_d;
  logic [VW-1:0] pend_vec_q, pend_vec_d;
  logic [LW-1:0] pend_lvl_q, pend_lvl_d;
  logic          ack_fire;

  assign ack_fire = irq_ack & pend_vld_q;

  // External pins
  logic [NUM_EXT-1:0] ext_req;
  for (genvar e = 0; e < NUM_EXT; e++) begin : g_ext
    irq_ext_input u_ext (
      .clk         (clk),
      .rst_n       (rst_n),
      .pin_n_i     (ext_pin_n[e]),
      .edge_mode_i (trig_q[e]),
      .clr_i       (ack_fire && (pend_vec_q == VW'(e))),
      .req_o       (ext_req[e])
    );
  end

  logic [NUM_SRC-1:0]         elig;
  logic [NUM_SRC-1:0][LW-1:0] src_lvl;
  logic [NUM_LVL-1:0]         lvl_active, lvl_allow;
  logic                       win_vld;
  logic [VW-1:0]              win_vec;
  logic [LW-1:0]              win_lvl;

  assign elig = {periph_req, ext_req} & en_q & {NUM_SRC{gen_q}};

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_lvl
    assign src_lvl[s] = LW'({phi_q[s], plo_q[s]});
  end

  irq_arbiter #(.NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL)) u_arb (
    .req_i       (elig),
    .lvl_i       (src_lvl),
    .allow_i     (lvl_allow),
    .win_valid_o (win_vld),
    .win_vec_o   (win_vec),
    .win_lvl_o   (win_lvl)
  );

  irq_nest_track #(.NUM_LVL(NUM_LVL)) u_nest (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_i     (ack_fire),
    .ack_lvl_i (pend_lvl_q),
    .ret_i     (irq_ret),
    .active_o  (lvl_active),
    .allow_o   (lvl_allow)
  );

  always_comb begin
    pend_vld_d = pend_vld_q;
    pend_vec_d = pend_vec_q;
    pend_lvl_d = pend_lvl_q;
    if (ack_fire) begin
      pend_vld_d = 1'b0;
    end else if (insn_start) begin
      pend_vld_d = win_vld;
      pend_vec_d = win_vec;
      pend_lvl_d = win_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld_q <= 1'b0;
      pend_vec_q <= '0;
      pend_lvl_q <= '0;
    end else if (ack_fire || insn_start) begin
      pend_vld_q <= pend_vld_d;
      pend_vec_q <= pend_vec_d;
      pend_lvl_q <= pend_lvl_d;
    end
  end

  assign irq_req = pend_vld_q;
  assign irq_vec = pend_vec_q;
  assign wake    = sleep & gen_q & (|(ext_req & en_q[NUM_EXT-1:0]));

  // R6
  pend_above_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_vld_q |-> ((lvl_active >> pend_lvl_q) == '0));

  // R7
  top_level_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_active[NUM_LVL-1] && insn_start && !irq_ret |=> !irq_req);

  // R2
  global_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_q && !cfg_we && insn_start |=> !irq_req);

  // R12
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec < VW'(NUM_SRC)));

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_start && !irq_ack |=> $stable(irq_req) && $stable(irq_vec));

  // R11
  wake_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep |-> !wake);
endmodule

// File: tb/irq_nest_ctrl_test.sv
module irq_nest_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [7:0] cfg_wdata = '0;
  logic [1:0] ext_pin_n = 2'b11;
  logic [9:0] periph_req = '0;
  logic       insn_start = 1'b0;
  logic       sleep = 1'b0;
  logic       irq_ack = 1'b0;
  logic       irq_ret = 1'b0;
  logic       irq_req;
  logic [3:0] irq_vec;
  logic       wake;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_nest_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .ext_pin_n(ext_pin_n), .periph_req(periph_req),
    .insn_start(insn_start), .sleep(sleep), .irq_ack(irq_ack),
    .irq_ret(irq_ret), .irq_req(irq_req), .irq_vec(irq_vec), .wake(wake)
  );

  // Scoreboard: {valid, vector} and a tag per expected election
  logic [4:0] exp_q[$];
  string      tag_q[$];
  logic       due = 1'b0;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) due <= insn_start;

  always @(negedge clk) begin
    if (due && exp_q.size() > 0) begin
      logic [4:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check({t, " req"}, int'(irq_req), int'(e[4]));
      if (e[4]) check({t, " vec"}, int'(irq_vec), int'(e[3:0]));
    end
  end

  task automatic cfg(input logic [2:0] sel, input logic [7:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic boundary(input logic v, input int vec, input string tag);
    exp_q.push_back({v, 4'(vec)});
    tag_q.push_back(tag);
    @(negedge clk);
    insn_start = 1'b1;
    @(negedge clk);
    insn_start = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic pulse_ret();
    @(negedge clk); irq_ret = 1'b1;
    @(negedge clk); irq_ret = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 irq_req after reset", int'(irq_req), 0);
    check("R1 wake after reset", int'(wake), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    boundary(1'b0, 0, "R1 no request with everything disabled");

    cfg(3'd0, 8'hFF);
    cfg(3'd1, 8'h1F);

    // R5 tie at level 0: sources 3 and 5
    periph_req[1] = 1'b1;
    periph_req[3] = 1'b1;
    boundary(1'b1, 3, "R5 same level lowest index");

    // R3/R4: source 3 low bit -> level 1, source 5 high bit -> level 2
    cfg(3'd2, 8'h08);
    cfg(3'd4, 8'h20);
    boundary(1'b1, 5, "R4 higher level beats rank");

    // R6: take level 2; source 7 also level 2 must wait
    pulse_ack();
    cfg(3'd4, 8'hA0);
    periph_req[5] = 1'b1;
    boundary(1'b0, 0, "R6 same or lower level waits");

    // R6: source 9 at level 3 preempts
    cfg(3'd3, 8'h02);
    cfg(3'd5, 8'h02);
    periph_req[7] = 1'b1;
    boundary(1'b1, 9, "R6 strictly higher preempts");
    pulse_ack();

    // R7: source 10 also at level 3, level 3 in service
    cfg(3'd3, 8'h06);
    cfg(3'd5, 8'h06);
    periph_req[8] = 1'b1;
    boundary(1'b0, 0, "R7 level 3 never preempted");

    // R8: return pops level 3 only; level 2 still blocks sources 5 and 7
    pulse_ret();
    boundary(1'b1, 9, "R8 return reopens level 3");
    periph_req[7] = 1'b0;
    periph_req[8] = 1'b0;
    boundary(1'b0, 0, "R8 level 2 still in service");
    pulse_ret();
    boundary(1'b1, 5, "R8 second return reopens level 2");

    // R2 per-source and global enable
    cfg(3'd0, 8'hDF);
    boundary(1'b1, 7, "R2 source 5 disabled");
    cfg(3'd0, 8'h5F);
    boundary(1'b0, 0, "R2 global enable off");
    cfg(3'd0, 8'hFF);
    periph_req = '0;
    boundary(1'b0, 0, "R12 request drops at next boundary");

    // R9 edge mode on pin 0
    cfg(3'd6, 8'h01);
    @(negedge clk); ext_pin_n[0] = 1'b0;
    @(negedge clk); ext_pin_n[0] = 1'b1;
    boundary(1'b1, 0, "R9 falling edge latched");
    pulse_ack();
    pulse_ret();
    boundary(1'b0, 0, "R9 flag cleared by acknowledge");

    // R10 level mode on pin 1
    @(negedge clk); ext_pin_n[1] = 1'b0;
    boundary(1'b1, 1, "R10 low pin requests");
    ext_pin_n[1] = 1'b1;
    boundary(1'b0, 0, "R10 no latch after pin rises");

    // R11 wake
    sleep = 1'b1;
    ext_pin_n[1] = 1'b0;
    #1;
    check("R11 wake on level pin", int'(wake), 1);
    cfg(3'd0, 8'hFD);
    #1;
    check("R11 no wake with source disabled", int'(wake), 0);
    ext_pin_n[1] = 1'b1;
    cfg(3'd0, 8'hFF);
    @(negedge clk); ext_pin_n[0] = 1'b0;
    #1;
    check("R11 edge pin before sampling edge", int'(wake), 0);
    @(negedge clk);
    #1;
    check("R11 wake after edge latched", int'(wake), 1);
    sleep = 1'b0;
    #1;
    check("R11 no wake when awake", int'(wake), 0);

    repeat (3) @(negedge clk);
    check("R12 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule